// File: doc/BRIEF.md
# Command-Link Descriptor Register Loader

This block programs one DMA channel's register file from a packed descriptor held in memory. A one-cycle `start` pulse with a byte address makes it read a 32-bit header word through a simple valid/ready read port. It then reads one payload word for each header bit that selects a register, lowest bit first, from consecutive word addresses. Each word is placed on a register write port, tagged with the header bit position that selected it. The channel's register file decodes that position into a register.

Header bit 0 carries no payload word. It raises a one-cycle clear pulse so the channel resets its registers before any new word lands. Bits 30 and 31 load the low and high halves of the link address. If the low half has bit 0 set, the loader goes on to fetch the next descriptor from the link address with that bit masked off, so descriptors form a chain. The link state is emptied at every header, so a descriptor that loads no enabled link ends the chain. When the chain ends, `done` pulses. A failed read ends loading at once and pulses `err`.

Top module: `cmdlink_loader`

## Requirements
- R1: While and after reset, `busy`, `rd_req_valid`, `reg_wr_en`, `reg_clear`, `done` and `err` are all low.
- R2: A `start` pulse while idle fetches a header from `start_addr`. A `start` while `busy` is high is ignored and causes no fetch from its address.
- R3: After a header at address A, payload words are read from A+4, A+8, ... with one word for each payload-carrying header bit. The payload-carrying bits are 2 to 12, 14, 19, 20, 29, 30 and 31. They are written in ascending bit order, with `reg_wr_idx` equal to the bit position and `reg_wr_data` equal to the word read.
- R4: Header bit 0 consumes no word. It gives a single `reg_clear` pulse one cycle after the header response, and this pulse comes before any write from that descriptor.
- R5: Header bits 1, 13, 15 to 18 and 21 to 28 consume no word and produce no write. A header with no payload-carrying bit ends with no payload fetch.
- R6: Each `reg_wr_en` pulse comes exactly one cycle after the error-free response that carried its word. There is one pulse per word.
- R7: When the descriptor loaded bit 30 with bit 0 set, the next header is fetched from {bit 31 word, bit 30 word with bit 0 cleared}, truncated to `ADDR_W`.
- R8: When the loaded link word has bit 0 clear, or the descriptor loaded no link word, `done` pulses once, `busy` falls, and nothing more is fetched.
- R9: A response with `rd_rsp_err` high causes no write for that word. It pulses `err`, drops `busy`, stops all further fetches, and gives no `done`.
- R10: While `rd_req_valid` is high and `rd_req_ready` is low, the request stays valid and `rd_req_addr` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin loading a chain (one-cycle pulse) |
| start_addr | input | ADDR_W | Byte address of the first header |
| busy | output | 1 | Loader is working through a chain |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | ADDR_W | Byte address of the requested word |
| rd_rsp_valid | input | 1 | Read response valid |
| rd_rsp_data | input | 32 | Read response word |
| rd_rsp_err | input | 1 | Read response carries an error |
| reg_wr_en | output | 1 | Channel register write strobe |
| reg_wr_idx | output | 5 | Header bit position selecting the register |
| reg_wr_data | output | 32 | Value to write |
| reg_clear | output | 1 | Clear all channel registers |
| done | output | 1 | Chain finished without error (pulse) |
| err | output | 1 | Loading aborted by a read error (pulse) |

## Verification
Every result is registered, and the bench counts cycles from each read response.

| Result | Timing |
|---|---|
| Write strobe | One cycle after the response that carried its word |
| Clear pulse | One cycle after the header response |
| Next read request | One cycle after the response before it |
| `err` | One cycle after the failing response |
| `done` | Two cycles after the last response, because the link decision takes its own cycle |

The memory model samples and drives on the falling edge. It stamps each response with a cycle number and checks every write and clear strobe against that stamp plus one. Whole-descriptor results, such as write order, fetch addresses and the done and error counts, are compared only once `busy` has fallen.

// File: rtl/cldl_pkg.sv
package cldl_pkg;
  localparam int HDR_W = 32;
  localparam int IDX_W = $clog2(HDR_W);
  // header positions that each pull one payload word
  localparam logic [HDR_W-1:0] WORD_BITS = 32'hE018_5FFC;
  localparam int CLR_POS     = 0;
  localparam int LINK_LO_POS = 30;
  localparam int LINK_HI_POS = 31;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HREQ,
    ST_HWAIT,
    ST_WREQ,
    ST_WWAIT,
    ST_LINK
  } ld_state_e;
endpackage

// File: rtl/cldl_hdr_decode.sv
module cldl_hdr_decode
  import cldl_pkg::*;
(
  input  logic [HDR_W-1:0] hdr,
  output logic [HDR_W-1:0] word_bits,
  output logic             clr
);
  for (genvar i = 0; i < HDR_W; i++) begin : g_bit
    if (WORD_BITS[i]) begin : g_word
      assign word_bits[i] = hdr[i];
    end else begin : g_none
      assign word_bits[i] = 1'b0;
    end
  end
  assign clr = hdr[CLR_POS];
endmodule

// File: rtl/cldl_pick.sv
module cldl_pick #(
  parameter int W  = 32,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  pend,
  output logic [W-1:0]  hot,
  output logic [IW-1:0] idx
);
  logic [W:0] lower;
  assign lower[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : g_chain
    assign lower[i+1] = lower[i] | pend[i];
    assign hot[i]     = pend[i] & ~lower[i];
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (hot[i]) idx = idx | IW'(i);
    end
  end
endmodule

// File: rtl/cldl_link.sv
module cldl_link
  import cldl_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              cap,
  input  logic [IDX_W-1:0]  cap_idx,
  input  logic [HDR_W-1:0]  cap_data,
  output logic              link_en,
  output logic [ADDR_W-1:0] next_addr
);
  logic [HDR_W-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (rst || clr) lo_q <= '0;
    else if (cap && cap_idx == IDX_W'(LINK_LO_POS)) lo_q <= cap_data;
  end
  assign link_en = lo_q[0];

  if (ADDR_W > HDR_W) begin : g_wide
    localparam int HI_W = ADDR_W - HDR_W;
    logic [HI_W-1:0] hi_q;
    always_ff @(posedge clk) begin
      if (rst || clr) hi_q <= '0;
      else if (cap && cap_idx == IDX_W'(LINK_HI_POS)) hi_q <= cap_data[HI_W-1:0];
    end
    assign next_addr = {hi_q, lo_q[HDR_W-1:1], 1'b0};
  end else begin : g_narrow
    assign next_addr = {lo_q[HDR_W-1:1], 1'b0};
  end
endmodule

// File: rtl/cmdlink_loader.sv
module cmdlink_loader
  import cldl_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              busy,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [HDR_W-1:0]  rd_rsp_data,
  input  logic              rd_rsp_err,
  output logic              reg_wr_en,
  output logic [IDX_W-1:0]  reg_wr_idx,
  output logic [HDR_W-1:0]  reg_wr_data,
  output logic              reg_clear,
  output logic              done,
  output logic              err
);
  localparam int STEP = HDR_W / 8;

  ld_state_e         st;
  logic [ADDR_W-1:0] cur_addr, addr_inc, link_next;
  logic [HDR_W-1:0]  pend, pend_after, hdr_words, pick_hot;
  logic [IDX_W-1:0]  pick_idx;
  logic              hdr_clr, link_en, hdr_take, word_take;

  assign addr_inc   = cur_addr + ADDR_W'(STEP);
  assign pend_after = pend & ~pick_hot;
  assign hdr_take   = (st == ST_HWAIT) && rd_rsp_valid && !rd_rsp_err;
  assign word_take  = (st == ST_WWAIT) && rd_rsp_valid && !rd_rsp_err;
  assign busy       = (st != ST_IDLE);

  cldl_hdr_decode u_dec (
    .hdr       (rd_rsp_data),
    .word_bits (hdr_words),
    .clr       (hdr_clr)
  );

  cldl_pick #(.W(HDR_W), .IW(IDX_W)) u_pick (
    .pend (pend),
    .hot  (pick_hot),
    .idx  (pick_idx)
  );

  cldl_link #(.ADDR_W(ADDR_W)) u_link (
    .clk       (clk),
    .rst       (rst),
    .clr       (hdr_take),
    .cap       (word_take),
    .cap_idx   (pick_idx),
    .cap_data  (rd_rsp_data),
    .link_en   (link_en),
    .next_addr (link_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      cur_addr     <= '0;
      pend         <= '0;
      rd_req_valid <= 1'b0;
      rd_req_addr  <= '0;
      reg_wr_en    <= 1'b0;
      reg_wr_idx   <= '0;
      reg_wr_data  <= '0;
      reg_clear    <= 1'b0;
      done         <= 1'b0;
      err          <= 1'b0;
    end else begin
      reg_wr_en <= 1'b0;
      reg_clear <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            cur_addr     <= start_addr;
            rd_req_addr  <= start_addr;
            rd_req_valid <= 1'b1;
            st           <= ST_HREQ;
          end
        end
        ST_HREQ: begin
          if (rd_req_ready) begin
            rd_req_valid <= 1'b0;
            st           <= ST_HWAIT;
          end
        end
        ST_WREQ: begin
          if (rd_req_ready) begin
            rd_req_valid <= 1'b0;
            st           <= ST_WWAIT;
          end
        end
        ST_HWAIT: begin
          if (rd_rsp_valid) begin
            if (rd_rsp_err) begin
              err <= 1'b1;
              st  <= ST_IDLE;
            end else begin
              reg_clear <= hdr_clr;
              pend      <= hdr_words;
              cur_addr  <= addr_inc;
              if (|hdr_words) begin
                rd_req_addr  <= addr_inc;
                rd_req_valid <= 1'b1;
                st           <= ST_WREQ;
              end else begin
                st <= ST_LINK;
              end
            end
          end
        end
        ST_WWAIT: begin
          if (rd_rsp_valid) begin
            if (rd_rsp_err) begin
              err <= 1'b1;
              st  <= ST_IDLE;
            end else begin
              reg_wr_en   <= 1'b1;
              reg_wr_idx  <= pick_idx;
              reg_wr_data <= rd_rsp_data;
              pend        <= pend_after;
              cur_addr    <= addr_inc;
              if (|pend_after) begin
                rd_req_addr  <= addr_inc;
                rd_req_valid <= 1'b1;
                st           <= ST_WREQ;
              end else begin
                st <= ST_LINK;
              end
            end
          end
        end
        ST_LINK: begin
          if (link_en) begin
            cur_addr     <= link_next;
            rd_req_addr  <= link_next;
            rd_req_valid <= 1'b1;
            st           <= ST_HREQ;
          end else begin
            done <= 1'b1;
            st   <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmdlink_loader_chk.sv
module cmdlink_loader_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_req_addr,
  input logic              rd_rsp_valid,
  input logic              rd_rsp_err,
  input logic              reg_wr_en,
  input logic              reg_clear,
  input logic              done,
  input logic              err
);
  a_r10_req_hold: assert property (@(posedge clk) disable iff (rst)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));

  a_r6_write_after_rsp: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en |-> $past(rd_rsp_valid && !rd_rsp_err));

  a_r9_err_after_bad_rsp: assert property (@(posedge clk) disable iff (rst)
    err |-> $past(rd_rsp_valid && rd_rsp_err));

  a_r9_err_stops: assert property (@(posedge clk) disable iff (rst)
    err |-> (!busy && !rd_req_valid));

  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !rd_req_valid));

  a_r4_events_apart: assert property (@(posedge clk) disable iff (rst)
    $onehot0({reg_wr_en, reg_clear, done, err}));

  a_r2_req_when_busy: assert property (@(posedge clk) disable iff (rst)
    rd_req_valid |-> busy);
endmodule

bind cmdlink_loader cmdlink_loader_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/cmdlink_loader_test.sv
`timescale 1ns/1ps
module cmdlink_loader_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] start_addr = '0;
  logic        busy, rd_req_valid, reg_wr_en, reg_clear, done, err;
  logic        rd_req_ready = 1'b0;
  logic [31:0] rd_req_addr, reg_wr_data;
  logic        rd_rsp_valid = 1'b0;
  logic [31:0] rd_rsp_data = '0;
  logic        rd_rsp_err = 1'b0;
  logic [4:0]  reg_wr_idx;

  always #4 clk = ~clk;

  cmdlink_loader #(.ADDR_W(32)) uut (.*);

  int checks = 0, fails = 0;
  logic [31:0] mem [0:255];
  int stall_len = 0;
  logic [31:0] err_addr = 32'hFFFF_FFF0;
  int cyc = 0, rsp_cyc = -10, wctr = 0;
  logic pflag = 1'b0;
  logic [31:0] paddr = '0, hold_addr = '0;

  int n_wr, n_fetch, n_clr, n_done, n_err, clr_cyc;
  logic [4:0]  wr_idx [0:63];
  logic [31:0] wr_dat [0:63];
  int          wr_cyc [0:63];
  logic [31:0] fetch  [0:63];
  logic [4:0]  x_idx  [0:63];
  logic [31:0] x_dat  [0:63];
  logic [31:0] x_fetch[0:63];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model and output monitor, all on the falling edge
  always @(negedge clk) begin
    cyc++;
    if (reg_wr_en) begin
      chk(cyc == rsp_cyc + 1, "R6 write one cycle after response", cyc, rsp_cyc + 1);
      if (n_wr < 64) begin
        wr_idx[n_wr] = reg_wr_idx; wr_dat[n_wr] = reg_wr_data; wr_cyc[n_wr] = cyc;
      end
      n_wr++;
    end
    if (reg_clear) begin
      chk(cyc == rsp_cyc + 1, "R4 clear one cycle after header", cyc, rsp_cyc + 1);
      n_clr++; clr_cyc = cyc;
    end
    if (done) n_done++;
    if (err)  n_err++;
    rd_rsp_valid = 1'b0;
    rd_rsp_err   = 1'b0;
    if (pflag) begin
      rd_rsp_valid = 1'b1;
      rd_rsp_data  = mem[paddr[9:2]];
      rd_rsp_err   = (paddr == err_addr);
      rsp_cyc      = cyc;
      pflag        = 1'b0;
    end
    if (rd_req_valid) begin
      if (wctr == 0) hold_addr = rd_req_addr;
      else chk(rd_req_addr == hold_addr, "R10 address held in stall", rd_req_addr, hold_addr);
      if (wctr < stall_len) begin
        rd_req_ready = 1'b0; wctr++;
      end else begin
        rd_req_ready = 1'b1; wctr = 0;
        pflag = 1'b1; paddr = rd_req_addr;
        if (n_fetch < 64) fetch[n_fetch] = rd_req_addr;
        n_fetch++;
      end
    end else begin
      rd_req_ready = 1'b0;
    end
  end

  task automatic clear_logs();
    n_wr = 0; n_fetch = 0; n_clr = 0; n_done = 0; n_err = 0; clr_cyc = 0;
  endtask

  task automatic pulse_start(input logic [31:0] a);
    @(negedge clk); start = 1'b1; start_addr = a;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle();
    int t = 0;
    while (busy && t < 5000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic compare(input string req, input int ew, input int ef, input int ed, input int ee);
    chk(n_wr == ew, {req, " write count"}, n_wr, ew);
    for (int k = 0; k < ew && k < n_wr; k++) begin
      chk(wr_idx[k] == x_idx[k], {req, " write index"}, wr_idx[k], x_idx[k]);
      chk(wr_dat[k] == x_dat[k], {req, " write data"}, wr_dat[k], x_dat[k]);
    end
    chk(n_fetch == ef, {req, " fetch count"}, n_fetch, ef);
    for (int k = 0; k < ef && k < n_fetch; k++)
      chk(fetch[k] == x_fetch[k], {req, " fetch address"}, fetch[k], x_fetch[k]);
    chk(n_done == ed, {req, " done count"}, n_done, ed);
    chk(n_err == ee, {req, " err count"}, n_err, ee);
    chk(busy == 1'b0, {req, " busy after end"}, busy, 0);
  endtask

  task automatic t_reset();
    chk(busy == 0 && rd_req_valid == 0, "R1 idle after reset", {busy, rd_req_valid}, 0);
    chk(reg_wr_en == 0 && reg_clear == 0 && done == 0 && err == 0,
        "R1 no strobes after reset", {reg_wr_en, reg_clear, done, err}, 0);
  endtask

  // R3 R8: sparse header, link word zero ends the chain
  task automatic t_sparse();
    logic [31:0] d [0:4] = '{32'h1111_0003, 32'h2000_1000, 32'h3000_2000, 32'h0000_0040, 32'h0};
    logic [4:0]  b [0:4] = '{5'd3, 5'd4, 5'd6, 5'd8, 5'd30};
    mem[16] = (32'h1 << 3) | (32'h1 << 4) | (32'h1 << 6) | (32'h1 << 8) | (32'h1 << 30);
    x_fetch[0] = 32'h40;
    for (int k = 0; k < 5; k++) begin
      mem[17 + k] = d[k]; x_idx[k] = b[k]; x_dat[k] = d[k];
      x_fetch[k + 1] = 32'h44 + 32'(4 * k);
    end
    clear_logs(); pulse_start(32'h40); wait_idle();
    compare("R3 R8 sparse header", 5, 6, 1, 0);
  endtask

  // R4 R5: clear bit and reserved bits consume no word
  task automatic t_clear_reserved();
    mem[32] = 32'h1 | 32'h2 | (32'h1 << 13) | (32'h1 << 15) | (32'h1 << 25) | (32'h1 << 12);
    mem[33] = 32'h0004_0004;
    x_idx[0] = 5'd12; x_dat[0] = 32'h0004_0004;
    x_fetch[0] = 32'h80; x_fetch[1] = 32'h84;
    clear_logs(); pulse_start(32'h80); wait_idle();
    compare("R5 reserved bits", 1, 2, 1, 0);
    chk(n_clr == 1, "R4 clear count", n_clr, 1);
    chk(clr_cyc < wr_cyc[0], "R4 clear before write", clr_cyc, wr_cyc[0]);
  endtask

  // R5: header with only reserved bits
  task automatic t_empty();
    mem[12] = 32'h0000_0002;
    x_fetch[0] = 32'h30;
    clear_logs(); pulse_start(32'h30); wait_idle();
    compare("R5 empty header", 0, 1, 1, 0);
    chk(n_clr == 0, "R5 no clear", n_clr, 0);
  endtask

  // R7: two-descriptor chain
  task automatic t_chain();
    mem[0] = (32'h1 << 30) | (32'h1 << 31); mem[1] = 32'h0000_0101; mem[2] = 32'h0;
    mem[64] = (32'h1 << 14) | (32'h1 << 30); mem[65] = 32'hA5A5_A5A5; mem[66] = 32'h0;
    x_idx[0] = 5'd30; x_dat[0] = 32'h101;
    x_idx[1] = 5'd31; x_dat[1] = 32'h0;
    x_idx[2] = 5'd14; x_dat[2] = 32'hA5A5_A5A5;
    x_idx[3] = 5'd30; x_dat[3] = 32'h0;
    x_fetch[0] = 32'h0;   x_fetch[1] = 32'h4;   x_fetch[2] = 32'h8;
    x_fetch[3] = 32'h100; x_fetch[4] = 32'h104; x_fetch[5] = 32'h108;
    clear_logs(); pulse_start(32'h0); wait_idle();
    compare("R7 chain", 4, 6, 1, 0);
  endtask

  // R2 R8 R10: stalled port, start while busy, nonzero link without enable
  task automatic t_stall_busy();
    mem[48] = (32'h1 << 9) | (32'h1 << 30); mem[49] = 32'h0000_0100; mem[50] = 32'h0000_0200;
    x_idx[0] = 5'd9;  x_dat[0] = 32'h100;
    x_idx[1] = 5'd30; x_dat[1] = 32'h200;
    x_fetch[0] = 32'hC0; x_fetch[1] = 32'hC4; x_fetch[2] = 32'hC8;
    stall_len = 3;
    clear_logs(); pulse_start(32'hC0);
    repeat (2) @(negedge clk);
    pulse_start(32'h30);
    wait_idle();
    stall_len = 0;
    compare("R2 R8 R10 stall and busy start", 2, 3, 1, 0);
  endtask

  // R9: read errors on a payload word and on a header
  task automatic t_error();
    mem[56] = (32'h1 << 3) | (32'h1 << 4) | (32'h1 << 5) | 32'h1;
    mem[57] = 32'hCAFE_0001; mem[58] = 32'hCAFE_0002; mem[59] = 32'hCAFE_0003;
    x_idx[0] = 5'd3; x_dat[0] = 32'hCAFE_0001;
    x_fetch[0] = 32'hE0; x_fetch[1] = 32'hE4; x_fetch[2] = 32'hE8;
    err_addr = 32'hE8;
    clear_logs(); pulse_start(32'hE0); wait_idle();
    compare("R9 payload error", 1, 3, 0, 1);
    err_addr = 32'hE0;
    clear_logs(); pulse_start(32'hE0); wait_idle();
    compare("R9 header error", 0, 1, 0, 1);
    chk(n_clr == 0, "R9 no clear on bad header", n_clr, 0);
    err_addr = 32'hFFFF_FFF0;
  endtask

  bit finished = 1'b0;
  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    for (int k = 0; k < 256; k++) mem[k] = '0;
    clear_logs();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_sparse();
    t_clear_reserved();
    t_empty();
    t_chain();
    t_stall_busy();
    t_error();
    finished = 1'b1;
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      report();
    end
  end
endmodule